// File: doc/BRIEF.md
# Dual Bidirectional Parallel Port

This block provides two 8-bit general-purpose parallel ports, called A and B, behind a small processor register bus. Every port keeps an output latch and a direction register. Each direction bit decides whether its pin is driven from the latch (bit set) or left as an input (bit clear). The pad side of each port has three groups of signals: latch values, per-bit output enables, and raw pin levels. The raw pin levels are synchronized inside the block.

Software reaches the block through four register addresses. A write to a data register always updates the latch, whatever the direction bits hold. A read of a data register is assembled bit by bit. Output bits return the latch value. Input bits return the synchronized pin level. Reset clears the direction registers, which turns every pin into an input. The latches keep their contents through reset, so software can preload output values before it enables any driver.

Top module: `dual_port_gpio`

## Requirements
- R1: Each pin's output enable equals its direction bit, and its output value equals the matching latch bit. A direction bit of 1 means the pin is an output.
- R2: An active-low reset clears both direction registers to 0x00, so every output enable goes low. Reset leaves both latches unchanged. The latches are not initialized by reset.
- R3: A write to a data register stores the write data in that port's latch on the next rising edge. This happens for every bit, including bits whose direction bit is 0.
- R4: A read of a data register returns, for each bit, the latch bit if the direction bit is 1 and the synchronized pin bit if the direction bit is 0.
- R5: Pin inputs pass through two synchronizer flops. After a pin changes, reads accepted on the first and second rising edges return the old level. A read accepted on the third rising edge returns the new level.
- R6: A read of a direction register returns its stored value.
- R7: A read of an address outside the four mapped ones returns 0x00. A write to such an address changes no latch and no direction bit.
- R8: Read data is registered. It appears after the rising edge that accepts the read strobe, and it shows the register contents from before any write accepted on that same edge. In a cycle with no read, read data is 0x00.
- R9: The full 16-bit address is decoded. Port A data is at 0x0000, port B data at 0x0001, port A direction at 0x0004 and port B direction at 0x0005.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Register address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data |
| portAIn | input | 8 | Raw pin levels, port A |
| portAOut | output | 8 | Latch value driven to port A pins |
| portAOe | output | 8 | Per-bit output enable, port A |
| portBIn | input | 8 | Raw pin levels, port B |
| portBOut | output | 8 | Latch value driven to port B pins |
| portBOe | output | 8 | Per-bit output enable, port B |

## Verification
A read and a write can both be accepted on the same edge for the same register. The bench raises both strobes at the direction address with new write data. It expects the read data to hold the old direction value and a following read to return the new one. A pin change can also coincide with a continuous read of an input port. The bench raises the read strobe in the same cycle as the pin change and checks each of the next three read results against the two-flop latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_PORTS = 2;

  typedef struct packed {
    logic [NUM_PORTS-1:0] wrLatch;
    logic [NUM_PORTS-1:0] wrDir;
    logic [NUM_PORTS-1:0] rdLatch;
    logic [NUM_PORTS-1:0] rdDir;
    logic                 rdEn;
  } busStrobe_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_BASE = 0,
  parameter int DIR_BASE  = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output busStrobe_t        strobe
);
  always_comb begin
    strobe       = '0;
    strobe.rdEn  = busRd;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (busAddr == ADDR_W'(DATA_BASE + p)) begin
        strobe.wrLatch[p] = busWr;
        strobe.rdLatch[p] = busRd;
      end
      if (busAddr == ADDR_W'(DIR_BASE + p)) begin
        strobe.wrDir[p] = busWr;
        strobe.rdDir[p] = busRd;
      end
    end
  end
endmodule

// File: rtl/gpio_dp.sv
module gpio_dp
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  busStrobe_t                      strobe,
  input  logic [WIDTH-1:0]                wrData,
  input  logic [NUM_PORTS-1:0][WIDTH-1:0] pinIn,
  output logic [NUM_PORTS-1:0][WIDTH-1:0] pinOut,
  output logic [NUM_PORTS-1:0][WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0]                rdData
);
  logic [NUM_PORTS-1:0][WIDTH-1:0] latchQ;
  logic [NUM_PORTS-1:0][WIDTH-1:0] dirQ;
  logic [NUM_PORTS-1:0][WIDTH-1:0] pinSync;
  logic [WIDTH-1:0]                rdSel;
  logic [WIDTH-1:0]                rdQ;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gSync
    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) uSync (
      .clk  (clk),
      .rstN (rstN),
      .din  (pinIn[p]),
      .dout (pinSync[p])
    );
  end

  // Direction registers: cleared by reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strobe.wrDir[p]) dirQ[p] <= wrData;
      end
    end
  end

  // Output latches: deliberately without reset.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strobe.wrLatch[p]) latchQ[p] <= wrData;
    end
  end

  always_comb begin
    rdSel = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strobe.rdLatch[p])
        rdSel |= (dirQ[p] & latchQ[p]) | (~dirQ[p] & pinSync[p]);
      if (strobe.rdDir[p])
        rdSel |= dirQ[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdQ <= '0;
    else if (strobe.rdEn) rdQ <= rdSel;
    else                  rdQ <= '0;
  end

  assign pinOut = latchQ;
  assign pinOe  = dirQ;
  assign rdData = rdQ;
endmodule

// File: rtl/dual_port_gpio.sv
module dual_port_gpio
  import gpio_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_BASE   = 0,
  parameter int DIR_BASE    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  portAIn,
  output logic [WIDTH-1:0]  portAOut,
  output logic [WIDTH-1:0]  portAOe,
  input  logic [WIDTH-1:0]  portBIn,
  output logic [WIDTH-1:0]  portBOut,
  output logic [WIDTH-1:0]  portBOe
);
  busStrobe_t                      strobe;
  logic [NUM_PORTS-1:0][WIDTH-1:0] pinIn;
  logic [NUM_PORTS-1:0][WIDTH-1:0] pinOut;
  logic [NUM_PORTS-1:0][WIDTH-1:0] pinOe;

  assign pinIn = {portBIn, portAIn};

  gpio_ctrl #(.ADDR_W(ADDR_W), .DATA_BASE(DATA_BASE), .DIR_BASE(DIR_BASE)) uCtrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strobe  (strobe)
  );

  gpio_dp #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (busWrData),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .rdData (busRdData)
  );

  assign portAOut = pinOut[0];
  assign portBOut = pinOut[1];
  assign portAOe  = pinOe[0];
  assign portBOe  = pinOe[1];
endmodule

// File: rtl/gpio_chk.sv
module gpio_chk #(
  parameter int ADDR_W    = 16,
  parameter int WIDTH     = 8,
  parameter int DATA_BASE = 0,
  parameter int DIR_BASE  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [WIDTH-1:0]  busWrData,
  input logic [WIDTH-1:0]  busRdData,
  input logic [WIDTH-1:0]  portAOut,
  input logic [WIDTH-1:0]  portAOe,
  input logic [WIDTH-1:0]  portBOut,
  input logic [WIDTH-1:0]  portBOe
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_BASE);
  localparam logic [ADDR_W-1:0] B_DATA = ADDR_W'(DATA_BASE + 1);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_BASE);
  localparam logic [ADDR_W-1:0] B_DIR  = ADDR_W'(DIR_BASE + 1);

  logic unmapped;
  assign unmapped = (busAddr != A_DATA) && (busAddr != B_DATA) &&
                    (busAddr != A_DIR)  && (busAddr != B_DIR);

  AST_DIR_CLEAR_AT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (portAOe == '0 && portBOe == '0)); // R2

  AST_LATCH_A_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_DATA) |=> portAOut == $past(busWrData)); // R3

  AST_LATCH_B_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == B_DATA) |=> $stable(portBOut)); // R7

  AST_DIR_A_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == A_DIR) |=> $stable(portAOe)); // R1

  AST_DIR_A_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == A_DIR) |=> busRdData == $past(portAOe)); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && unmapped) |=> busRdData == '0); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> busRdData == '0); // R8
endmodule

bind dual_port_gpio gpio_chk #(
  .ADDR_W(ADDR_W), .WIDTH(WIDTH), .DATA_BASE(DATA_BASE), .DIR_BASE(DIR_BASE)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRd     (busRd),
  .busWr     (busWr),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .portAOut  (portAOut),
  .portAOe   (portAOe),
  .portBOut  (portBOut),
  .portBOe   (portBOe)
);

// File: tb/sim_dual_port_gpio.sv
module sim_dual_port_gpio;
  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] addr = '0;
  logic        rd = 0;
  logic        wr = 0;
  logic [7:0]  wd = '0;
  logic [7:0]  pinA = 8'h0F;
  logic [7:0]  pinB = 8'hF0;
  logic [7:0]  rdData, outA, oeA, outB, oeB;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_port_gpio u0 (
    .clk(clk), .rstN(rstN), .busAddr(addr), .busRd(rd), .busWr(wr),
    .busWrData(wd), .busRdData(rdData),
    .portAIn(pinA), .portAOut(outA), .portAOe(oeA),
    .portBIn(pinB), .portBOut(outB), .portBOe(oeB)
  );

  // Behavioural reference model
  logic [7:0] mLatch [2];
  logic [7:0] mKnown [2] = '{8'h00, 8'h00};
  logic [7:0] mDir   [2];
  logic [7:0] mS1    [2];
  logic [7:0] mS2    [2];
  logic [7:0] mRd;
  logic [7:0] nxtRd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDir[0] = 0; mDir[1] = 0;
      mS1[0] = 0; mS1[1] = 0; mS2[0] = 0; mS2[1] = 0;
      mRd = 0;
    end else begin
      nxtRd = 0;
      if (rd) begin
        if (addr == 16'h0000) nxtRd = (mDir[0] & mLatch[0]) | (~mDir[0] & mS2[0]);
        if (addr == 16'h0001) nxtRd = (mDir[1] & mLatch[1]) | (~mDir[1] & mS2[1]);
        if (addr == 16'h0004) nxtRd = mDir[0];
        if (addr == 16'h0005) nxtRd = mDir[1];
      end
      mRd = nxtRd;
      if (wr) begin
        if (addr == 16'h0000) begin mLatch[0] = wd; mKnown[0] = 8'hFF; end
        if (addr == 16'h0001) begin mLatch[1] = wd; mKnown[1] = 8'hFF; end
        if (addr == 16'h0004) mDir[0] = wd;
        if (addr == 16'h0005) mDir[1] = wd;
      end
      mS2[0] = mS1[0]; mS2[1] = mS1[1];
      mS1[0] = pinA;   mS1[1] = pinB;
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp,
                       input logic [7:0] mask, input string tag);
    testCount++;
    if (((act ^ exp) & mask) != 0) begin
      failCount++;
      $display("FAIL %s: actual %02h expected %02h (mask %02h)", tag, act, exp, mask);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(rdData, mRd, 8'hFF, "R8 model read data");
      check(oeA, mDir[0], 8'hFF, "R1 model oe A");
      check(oeB, mDir[1], 8'hFF, "R1 model oe B");
      check(outA, mLatch[0], mKnown[0], "R3 model out A");
      check(outB, mLatch[1], mKnown[1], "R3 model out B");
    end
  end

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #2; addr = a; wd = d; wr = 1;
    @(posedge clk); #2; wr = 0;
  endtask

  task automatic busRead(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #2; addr = a; rd = 1;
    @(posedge clk); #2; rd = 0;
    check(rdData, exp, 8'hFF, tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rstN = 1;
    check(oeA, 8'h00, 8'hFF, "R2 oe A after reset");
    check(oeB, 8'h00, 8'hFF, "R2 oe B after reset");
    check(rdData, 8'h00, 8'hFF, "R8 idle read data");

    busWrite(16'h0000, 8'hA5);
    check(outA, 8'hA5, 8'hFF, "R3 latch A written while input");
    check(oeA, 8'h00, 8'hFF, "R3 pin stays input");
    busWrite(16'h0001, 8'h3C);
    busWrite(16'h0004, 8'hF0);
    busWrite(16'h0005, 8'h0F);
    check(oeA, 8'hF0, 8'hFF, "R1 oe A follows direction");
    check(outB, 8'h3C, 8'hFF, "R1 out B follows latch");

    busRead(16'h0000, 8'hAF, "R4 mixed read A");
    busRead(16'h0001, 8'hFC, "R4 mixed read B");
    busRead(16'h0004, 8'hF0, "R6 direction A");
    busRead(16'h0005, 8'h0F, "R6 direction B");

    busRead(16'h0002, 8'h00, "R7 unmapped read");
    busRead(16'h0100, 8'h00, "R9 high address bits decoded");
    busRead(16'h0104, 8'h00, "R9 alias of direction A");
    busWrite(16'h0002, 8'hFF);
    busWrite(16'h0104, 8'hFF);
    check(oeA, 8'hF0, 8'hFF, "R7 direction untouched");
    check(outA, 8'hA5, 8'hFF, "R7 latch untouched");
    busRead(16'h0000, 8'hAF, "R7 read A after unmapped write");

    // Same-cycle read and write of direction A
    @(posedge clk); #2; addr = 16'h0004; wd = 8'h33; rd = 1; wr = 1;
    @(posedge clk); #2; rd = 0; wr = 0;
    check(rdData, 8'hF0, 8'hFF, "R8 read sees old value on write edge");
    busRead(16'h0004, 8'h33, "R8 new value afterwards");

    // Synchronizer latency
    busWrite(16'h0004, 8'h00);
    @(posedge clk); #2; pinA = 8'h55; addr = 16'h0000; rd = 1;
    @(posedge clk); #2; check(rdData, 8'h0F, 8'hFF, "R5 first edge old level");
    @(posedge clk); #2; check(rdData, 8'h0F, 8'hFF, "R5 second edge old level");
    @(posedge clk); #2; check(rdData, 8'h55, 8'hFF, "R5 third edge new level");
    rd = 0;

    // Latches across reset
    busWrite(16'h0000, 8'h5A);
    busWrite(16'h0001, 8'hC3);
    busWrite(16'h0004, 8'hFF);
    busWrite(16'h0005, 8'hFF);
    @(posedge clk); #2; rstN = 0;
    #3;
    check(oeA, 8'h00, 8'hFF, "R2 reset clears direction A");
    check(oeB, 8'h00, 8'hFF, "R2 reset clears direction B");
    check(outA, 8'h5A, 8'hFF, "R2 latch A kept in reset");
    check(outB, 8'hC3, 8'hFF, "R2 latch B kept in reset");
    repeat (2) @(posedge clk);
    #2; rstN = 1;
    busWrite(16'h0004, 8'hFF);
    busRead(16'h0000, 8'h5A, "R2 latch A readable after reset");
    check(outB, 8'hC3, 8'hFF, "R2 latch B after reset");

    repeat (2) @(posedge clk);
    #2; done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule